// File: doc/BRIEF.md
# DDS Phase Accumulator with Modulation Controls

This block is the phase engine of a direct digital synthesizer. On every clock it adds a frequency step to a wide phase accumulator. The step is the sum of up to three frequency words: a centre word that is always used, an offset word that a pin can gate for frequency-shift keying, and a serial word that a control bit can switch off. The accumulator wraps at its full width. Its top bits, plus a quadrant offset picked by two pins for phase-shift keying, form the phase code that drives a sine lookup further down the chain.

Software programs the frequency words and the control bits over a narrow parallel write bus into shadow registers. Nothing changes the synthesized frequency until an update copies every shadow register into its active register. An update is caused either by a rising edge on the update pin or by a write of any data to the highest bus address. All four control pins are asynchronous to the clock and are each passed through a multi-stage synchronizer before use.

Top module: `dds_phase_core`

## Requirements
- R1: While reset is asserted the phase output is 0. Reset loads the active and shadow centre words with 0x4000_0000_0000 (a quarter of the clock rate), clears the offset and serial words, and sets the control bits to offset-off (bit 0 = 0) and serial-on (bit 1 = 1).
- R2: On every rising clock edge the accumulator takes its previous value plus the step, which is centre + gated offset + gated serial, all modulo 2^48. The phase output is the top 14 accumulator bits plus the quadrant term of R3.
- R3: The synchronized 2-bit phase-select code q adds q × 2^12 modulo 2^14 to the phase output: 0, 90, 180 or 270 degrees.
- R4: The bus writes 16-bit slices. Address 3·k + j (k = 0 centre, 1 offset, 2 serial; j = 0 for bits 15:0, 1 for bits 31:16, 2 for bits 47:32) writes a shadow word. Address 9 writes the shadow control bits from data bits 1:0. A shadow write does not change the accumulated step.
- R5: A write of any data to address 15 copies all shadow registers into the active registers on that same edge. The new step is used from the next edge.
- R6: A rising edge of the update pin, after synchronization, performs one update. Holding the pin high performs no further updates.
- R7: The offset word enters the step only when active control bit 0 is 1 and the synchronized offset-enable pin is 1. Otherwise it is replaced by zero.
- R8: The serial word enters the step only when active control bit 1 is 1.
- R9: A bus write presented on the first rising edge after reset is released is ignored.
- R10: A change on the phase-select or offset-enable pins takes effect only after passing through a 2-stage synchronizer.
- R11: Writes to addresses 10 to 14 change no register.
- R12: The accumulator wraps modulo 2^48, so a step of 2^48 − 1 lowers the phase, and a step of 0xC000_0000_0000 steps it by −90 degrees per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Synthesizer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 4 | Bus register address |
| wr_data | input | 16 | Bus write data |
| upd_pin | input | 1 | Asynchronous update request; a rising edge triggers one update |
| offen_pin | input | 1 | Asynchronous offset-word enable |
| psel_pin | input | 2 | Asynchronous quadrant phase select |
| phase_out | output | 14 | Phase code for the sine lookup |

## Verification
A bus write lands in shadow storage on the edge that samples it. An address-15 write makes the new step active on that same edge, so the accumulator first grows by the new step one edge later. A pin-driven update reaches the active registers on the third edge after the pin rises: two synchronizer stages plus the edge detector. A phase-select or offset-enable change reaches the output after two edges. The bench keeps an edge-accurate reference built from these latencies. It drives inputs and compares the phase output on falling edges, so every check compares against the value due in that exact cycle.

// File: rtl/dds_pkg.sv
package dds_pkg;

   // number of frequency words held in the register file
   localparam int NUM_WORDS = 3;

   // word indices inside the register file
   localparam int WORD_CENTER = 0;
   localparam int WORD_OFFSET = 1;
   localparam int WORD_SERIAL = 2;

   // control bits: bit 1 serial path on, bit 0 offset path on
   typedef struct packed {
      logic ser_on;
      logic off_on;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{ser_on: 1'b1, off_on: 1'b0};

endpackage

// File: rtl/dds_sync.sv
module dds_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[0] <= '0;
            else        stage[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[i] <= '0;
            else        stage[i] <= stage[i-1];
         end
      end
   end

   assign q = stage[STAGES-1];

endmodule

// File: rtl/dds_regfile.sv
module dds_regfile
   import dds_pkg::*;
#(
   parameter int FREQ_W = 48,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              upd_lvl,
   output logic [FREQ_W-1:0] center_act,
   output logic [FREQ_W-1:0] offset_act,
   output logic [FREQ_W-1:0] serial_act,
   output logic [FREQ_W-1:0] center_shd,
   output ctrl_t             ctrl_act,
   output logic              wr_ok,
   output logic              upd_now
);

   localparam int SLICES    = FREQ_W / DATA_W;
   localparam int CTRL_ADDR = NUM_WORDS * SLICES;
   localparam int UPD_ADDR  = (1 << ADDR_W) - 1;
   localparam logic [FREQ_W-1:0] CENTER_RST = {2'b01, {(FREQ_W-2){1'b0}}};

   logic              ready;
   logic              upd_prev;
   logic [FREQ_W-1:0] shadow [NUM_WORDS];
   logic [FREQ_W-1:0] active [NUM_WORDS];
   ctrl_t             ctrl_shd;
   logic              addr_upd;

   function automatic logic [FREQ_W-1:0] rst_word(input int w);
      return (w == WORD_CENTER) ? CENTER_RST : '0;
   endfunction

   // first edge after reset release only arms the bus
   assign wr_ok    = wr_en && ready;
   assign addr_upd = wr_ok && (int'(wr_addr) == UPD_ADDR);
   assign upd_now  = (upd_lvl && !upd_prev) || addr_upd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready    <= 1'b0;
         upd_prev <= 1'b0;
         ctrl_shd <= CTRL_RESET;
         ctrl_act <= CTRL_RESET;
         for (int w = 0; w < NUM_WORDS; w++) begin
            shadow[w] <= rst_word(w);
            active[w] <= rst_word(w);
         end
      end else begin
         ready    <= 1'b1;
         upd_prev <= upd_lvl;
         if (wr_ok) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
               for (int s = 0; s < SLICES; s++) begin
                  if (int'(wr_addr) == w * SLICES + s)
                     shadow[w][s*DATA_W +: DATA_W] <= wr_data;
               end
            end
            if (int'(wr_addr) == CTRL_ADDR)
               ctrl_shd <= ctrl_t'(wr_data[1:0]);
         end
         if (upd_now) begin
            active   <= shadow;
            ctrl_act <= ctrl_shd;
         end
      end
   end

   assign center_act = active[WORD_CENTER];
   assign offset_act = active[WORD_OFFSET];
   assign serial_act = active[WORD_SERIAL];
   assign center_shd = shadow[WORD_CENTER];

endmodule

// File: rtl/dds_accum.sv
module dds_accum #(
   parameter int FREQ_W  = 48,
   parameter int PHASE_W = 14,
   parameter bit OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FREQ_W-1:0]  center,
   input  logic [FREQ_W-1:0]  offset,
   input  logic [FREQ_W-1:0]  serial,
   input  logic               off_gate,
   input  logic               ser_gate,
   input  logic [1:0]         psel,
   output logic [FREQ_W-1:0]  acc,
   output logic [FREQ_W-1:0]  step,
   output logic [PHASE_W-1:0] phase
);

   localparam int QUAD_SHIFT = PHASE_W - 2;

   logic [FREQ_W-1:0]  off_term;
   logic [FREQ_W-1:0]  ser_term;
   logic [PHASE_W-1:0] phase_c;

   assign off_term = off_gate ? offset : '0;
   assign ser_term = ser_gate ? serial : '0;
   assign step     = center + off_term + ser_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else        acc <= acc + step;
   end

   assign phase_c = acc[FREQ_W-1 -: PHASE_W] + {psel, {QUAD_SHIFT{1'b0}}};

   if (OUT_REG) begin : g_out_reg
      logic [PHASE_W-1:0] phase_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) phase_q <= '0;
         else        phase_q <= phase_c;
      end
      assign phase = phase_q;
   end else begin : g_out_comb
      assign phase = phase_c;
   end

endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
   import dds_pkg::*;
#(
   parameter int FREQ_W      = 48,
   parameter int PHASE_W     = 14,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               upd_pin,
   input  logic               offen_pin,
   input  logic [1:0]         psel_pin,
   output logic [PHASE_W-1:0] phase_out
);

   localparam int SLICES  = FREQ_W / DATA_W;
   localparam int PIN_W   = 4;

   if (FREQ_W % DATA_W != 0) begin : g_err_slice
      $error("FREQ_W must be a multiple of DATA_W");
   end
   if (DATA_W < 2) begin : g_err_data
      $error("DATA_W must hold the two control bits");
   end
   if (PHASE_W < 3 || PHASE_W > FREQ_W) begin : g_err_phase
      $error("PHASE_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_err_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NUM_WORDS * SLICES >= (1 << ADDR_W) - 1) begin : g_err_addr
      $error("ADDR_W too small for the register map");
   end

   logic [PIN_W-1:0]  pins_s;
   logic [FREQ_W-1:0] act_center;
   logic [FREQ_W-1:0] act_offset;
   logic [FREQ_W-1:0] act_serial;
   logic [FREQ_W-1:0] shd_center;
   ctrl_t             ctrl_act;
   logic              wr_ok;
   logic              upd_now;
   logic [FREQ_W-1:0] acc_q;
   logic [FREQ_W-1:0] step;

   dds_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({upd_pin, offen_pin, psel_pin}),
      .q     (pins_s)
   );

   dds_regfile #(.FREQ_W(FREQ_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .upd_lvl    (pins_s[3]),
      .center_act (act_center),
      .offset_act (act_offset),
      .serial_act (act_serial),
      .center_shd (shd_center),
      .ctrl_act   (ctrl_act),
      .wr_ok      (wr_ok),
      .upd_now    (upd_now)
   );

   dds_accum #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .OUT_REG(OUT_REG)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .center   (act_center),
      .offset   (act_offset),
      .serial   (act_serial),
      .off_gate (ctrl_act.off_on && pins_s[2]),
      .ser_gate (ctrl_act.ser_on),
      .psel     (pins_s[1:0]),
      .acc      (acc_q),
      .step     (step),
      .phase    (phase_out)
   );

endmodule

// File: rtl/dds_phase_core_chk.sv
module dds_phase_core_chk #(
   parameter int FREQ_W = 48,
   parameter int ADDR_W = 4,
   parameter int CTRL_ADDR = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_ok,
   input logic              upd_now,
   input logic [FREQ_W-1:0] shd_center,
   input logic [FREQ_W-1:0] act_center,
   input logic [FREQ_W-1:0] acc,
   input logic [FREQ_W-1:0] step
);

   localparam int UPD_ADDR = (1 << ADDR_W) - 1;

   logic seen_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_edge <= 1'b0;
      else        seen_edge <= 1'b1;
   end

   AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> acc == $past(acc) + $past(step)); // R2

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_now |=> $stable(act_center)); // R4

   AST_UPDATE_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && int'(wr_addr) == UPD_ADDR) |=> act_center == $past(shd_center)); // R5

   AST_FIRST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_edge |-> !wr_ok); // R9

   AST_GAP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && int'(wr_addr) > CTRL_ADDR && int'(wr_addr) < UPD_ADDR)
      |=> $stable(shd_center)); // R11

endmodule

bind dds_phase_core dds_phase_core_chk #(
   .FREQ_W    (FREQ_W),
   .ADDR_W    (ADDR_W),
   .CTRL_ADDR (dds_pkg::NUM_WORDS * (FREQ_W / DATA_W))
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_addr    (wr_addr),
   .wr_ok      (wr_ok),
   .upd_now    (upd_now),
   .shd_center (shd_center),
   .act_center (act_center),
   .acc        (acc_q),
   .step       (step)
);

// File: tb/dds_phase_core_test.sv
module dds_phase_core_test;

   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        upd_pin = 1'b0;
   logic        offen_pin = 1'b0;
   logic [1:0]  psel_pin = '0;
   logic [13:0] phase_out;

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_tag = "R1";
   bit    mon_on = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   dds_phase_core uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .upd_pin   (upd_pin),
      .offen_pin (offen_pin),
      .psel_pin  (psel_pin),
      .phase_out (phase_out)
   );

   // ---------------- reference built from the requirements ----------------
   logic [47:0] m_c_shd, m_o_shd, m_s_shd, m_c_act, m_o_act, m_s_act, m_acc;
   logic [1:0]  m_ctl_shd, m_ctl_act;
   logic [3:0]  m_s1, m_s2;
   logic        m_prev, m_ready;
   logic        m_wok, m_upd;
   logic [47:0] m_step;
   logic [13:0] m_phase;

   assign m_wok   = wr_en && m_ready;
   assign m_upd   = (m_s2[3] && !m_prev) || (m_wok && wr_addr == 4'hF);
   assign m_step  = m_c_act + ((m_ctl_act[0] && m_s2[2]) ? m_o_act : 48'h0)
                    + (m_ctl_act[1] ? m_s_act : 48'h0);
   assign m_phase = m_acc[47:34] + {m_s2[1:0], 12'h000};

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_c_shd <= 48'h4000_0000_0000; m_c_act <= 48'h4000_0000_0000;
         m_o_shd <= '0; m_o_act <= '0; m_s_shd <= '0; m_s_act <= '0;
         m_ctl_shd <= 2'b10; m_ctl_act <= 2'b10;
         m_s1 <= '0; m_s2 <= '0; m_prev <= 1'b0; m_ready <= 1'b0; m_acc <= '0;
      end else begin
         m_ready <= 1'b1;
         m_s1    <= {upd_pin, offen_pin, psel_pin};
         m_s2    <= m_s1;
         m_prev  <= m_s2[3];
         if (m_wok) begin
            if (wr_addr < 4'd3)       m_c_shd[int'(wr_addr)*16 +: 16]       <= wr_data;
            else if (wr_addr < 4'd6)  m_o_shd[(int'(wr_addr)-3)*16 +: 16]   <= wr_data;
            else if (wr_addr < 4'd9)  m_s_shd[(int'(wr_addr)-6)*16 +: 16]   <= wr_data;
            else if (wr_addr == 4'd9) m_ctl_shd <= wr_data[1:0];
         end
         if (m_upd) begin
            m_c_act <= m_c_shd; m_o_act <= m_o_shd; m_s_act <= m_s_shd;
            m_ctl_act <= m_ctl_shd;
         end
         m_acc <= m_acc + m_step;
      end
   end

   task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s phase_out actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on && rst_n) chk(cur_tag, phase_out, m_phase);
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr48(input int base, input logic [47:0] v);
      wr(base,     v[15:0]);
      wr(base + 1, v[31:16]);
      wr(base + 2, v[47:32]);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
   end

   initial begin
      logic [47:0] centers [3];
      centers[0] = 48'h0;
      centers[1] = 48'h0004_0000_0000;
      centers[2] = 48'h4000_0000_0000;

      idle(4);
      chk("R1", phase_out, 14'h0);   // R1: phase held at zero in reset
      idle(1);
      chk("R1", phase_out, 14'h0);

      // R9: write on first edge after release is dropped, then alias update
      cur_tag = "R9";
      rst_n   = 1'b1;
      mon_on  = 1'b1;
      wr(2, 16'h0000);
      wr(15, 16'h0000);
      idle(6);

      cur_tag = "R1"; idle(4);     // R1: quarter-rate default step
      cur_tag = "R2"; idle(8);     // R2: plain accumulation

      cur_tag = "R4";               // R4: shadow writes stay inactive
      wr48(0, 48'h0123_4567_89AB);
      idle(8);

      cur_tag = "R5";               // R5: alias update with arbitrary data
      wr(15, 16'hBEEF);
      idle(8);

      cur_tag = "R6";               // R6: pin update, single per rising edge
      wr48(0, 48'h0800_0000_0001);
      idle(3);
      upd_pin = 1'b1; idle(8);
      wr48(0, 48'h1000_0000_0000);
      idle(5);
      upd_pin = 1'b0; idle(3);
      upd_pin = 1'b1; idle(1);
      upd_pin = 1'b0; idle(6);

      cur_tag = "R7";               // R7: offset gating by control bit and pin
      wr48(3, 48'h0400_0000_0000);
      wr(9, 16'h0003);
      wr(15, 16'h0000);
      for (int k = 0; k < 6; k++) begin
         offen_pin = k[0];
         idle(5);
      end
      offen_pin = 1'b1;
      wr(9, 16'h0002);
      wr(15, 16'h0000);
      idle(6);

      cur_tag = "R8";               // R8: serial gating by control bit
      wr48(6, 48'h0010_0000_0000);
      wr(9, 16'h0001);
      wr(15, 16'h0000);
      idle(6);
      wr(9, 16'h0003);
      wr(15, 16'h0000);
      idle(6);
      wr(9, 16'h0000);
      wr(15, 16'h0000);
      idle(6);

      cur_tag = "R11";              // R11: unmapped addresses ignored
      wr(10, 16'hFFFF);
      wr(12, 16'hFFFF);
      wr(14, 16'hFFFF);
      wr(15, 16'h0000);
      idle(6);

      cur_tag = "R3/R10";           // R3, R10: quadrant sweep via synchronizer
      for (int c = 0; c < 3; c++) begin
         wr48(0, centers[c]);
         wr(15, 16'h0000);
         for (int p = 0; p < 4; p++) begin
            psel_pin = p[1:0];
            idle(6);
         end
      end
      psel_pin = 2'd0;

      cur_tag = "R12";              // R12: modulo 2^48 wrap
      wr48(0, 48'hFFFF_FFFF_FFFF);
      wr(15, 16'h0000);
      idle(20);
      wr48(0, 48'hC000_0000_0000);
      wr(15, 16'h0000);
      idle(12);

      mon_on = 1'b0;
      summary();
   end

endmodule